// File: doc/BRIEF.md
# Multiplexed Bus Trace Capture Unit

This block listens, without driving anything, to a processor bus that shares eight lines between the low address byte and data. A fast system clock oversamples the bus lines and strobes. The block uses strobe edges to split the shared lines. A falling address-latch strobe yields an address record. This record also holds the level of the top address bit, so accesses to the low half (ROM) and the high half (RAM) can be told apart. A rising read strobe yields a read-data record, and a rising write strobe yields a write-data record.

Recording needs two steps. The block must first be armed, and then a trigger must fire. One trigger mode waits for the processor to leave reset, which shows as the reset-out line falling. The other mode waits for a falling edge, taken as a start bit, on one of two serial lines. A readout port returns any stored record by index, together with the number of records held. When the buffer fills, recording stops until the block is armed again.

Top module: `bus_trace_capture`

## Requirements
- R1: After reset, `rec_count` is 0 and both `full` and `capturing` are 0.
- R2: Bus strobe edges add no record while the block is unarmed, or while it is armed and no trigger has fired.
- R3: With `trig_mode`=0, a falling edge on `bus_rst_out` while armed sets `capturing`. With `trig_mode`=1, a falling edge on `bus_rst_out` has no effect.
- R4: With `trig_mode`=1, a falling edge on `ser_line[ser_pick]` while armed sets `capturing`. A falling edge on the other serial line has no effect.
- R5: While capturing, a falling edge on `bus_ale` stores a record with `rec[10:9]`=00, `rec[8]` equal to `bus_a15`, and `rec[7:0]` equal to `bus_ad`.
- R6: While capturing, a rising edge on `bus_rd_n` stores a record with `rec[10:9]`=01, `rec[8]`=0, and `rec[7:0]` equal to `bus_ad`.
- R7: While capturing, a rising edge on `bus_wr_n` stores a record with `rec[10:9]`=10, `rec[8]`=0, and `rec[7:0]` equal to `bus_ad`.
- R8: Records are stored at consecutive indices from 0 in the order their edges occur. `rec_count` is the number stored, and each new record is readable no later than the third clock edge after its strobe edge.
- R9: Edges of different kinds seen in the same clock cycle are stored in the order address, read, write.
- R10: Once DEPTH (64) records are held, `full` is 1, `capturing` is 0, `rec_count` stays at DEPTH, and further edges are ignored.
- R11: A pulse on `arm` clears `rec_count`, `full` and `capturing`, and recording then waits for a new trigger.
- R12: `rec` combinationally shows the record stored at index `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least 4x the strobe rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ad | input | 8 | Shared address/data lines |
| bus_ale | input | 1 | Address latch strobe, active high |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_a15 | input | 1 | Top address bit |
| bus_rst_out | input | 1 | Processor reset-out, high while the processor is in reset |
| ser_line | input | 2 | Two serial data lines, idle high |
| trig_mode | input | 1 | 0 = reset-release trigger, 1 = serial start-bit trigger |
| ser_pick | input | 1 | Selects which serial line the start-bit trigger watches |
| arm | input | 1 | Clears the trace and waits for a trigger |
| rd_idx | input | 6 | Readout index |
| rec | output | 11 | Record at `rd_idx`: {type[1:0], a15, byte[7:0]} |
| rec_count | output | 7 | Number of records held |
| full | output | 1 | Buffer holds DEPTH records |
| capturing | output | 1 | Trigger has fired and recording is active |

## Verification
The bench replays a processor leaving reset and fetching a three-byte jump, then fetching from the jump target. A design that latched data on the wrong strobe edge would return the address byte in place of C3/25/80. A design that dropped the top address bit would not show the jump into the upper half.

Address, read and write edges are made to coincide in one cycle. A design that kept only one of them, or stored them in another order, shows the wrong types at indices 0 to 2. Edges on the reset line and on the unselected serial line are sent in serial mode, and a trigger-mode mix-up would start recording early. Seventy writes then overrun the buffer. A design without a stop would wrap and overwrite index 0, or report a count above 64. A design whose arm did not clear state would keep the old count.

// File: rtl/bus_trace_capture.sv
`timescale 1ns/1ps
module bus_trace_capture #(
  parameter int DEPTH = 64,
  parameter int AW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [AW-1:0]                bus_ad,
  input  logic                         bus_ale,
  input  logic                         bus_rd_n,
  input  logic                         bus_wr_n,
  input  logic                         bus_a15,
  input  logic                         bus_rst_out,
  input  logic [1:0]                   ser_line,
  input  logic                         trig_mode,
  input  logic                         ser_pick,
  input  logic                         arm,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx,
  output logic [AW+2:0]                rec,
  output logic [$clog2(DEPTH+1)-1:0]   rec_count,
  output logic                         full,
  output logic                         capturing
);
  localparam int IW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = CW + 2;
  localparam int RW  = AW + 3;
  localparam int SW  = AW + 7;
  localparam int ALE = AW;
  localparam int RDN = AW + 1;
  localparam int WRN = AW + 2;
  localparam int A15 = AW + 3;
  localparam int RSO = AW + 4;
  localparam int SER = AW + 5;
  localparam logic [PW-1:0] DEP = PW'(DEPTH);

  logic [SW-1:0] s1, s2, sp;
  logic [RW-1:0] mem [DEPTH];
  logic [CW-1:0] count;
  logic armed;
  logic ale_fall, rd_rise, wr_rise, trig;
  logic [2:0] ev;
  logic [PW-1:0] pos0, pos1, pos2, total, nxt;
  logic [RW-1:0] rec_a, rec_r, rec_w;
  logic [1:0] ser_s2, ser_sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      sp <= '0;
    end else begin
      s1 <= {ser_line, bus_rst_out, bus_a15, bus_wr_n, bus_rd_n, bus_ale, bus_ad};
      s2 <= s1;
      sp <= s2;
    end
  end

  assign ale_fall = sp[ALE] & ~s2[ALE];
  assign rd_rise  = ~sp[RDN] & s2[RDN];
  assign wr_rise  = ~sp[WRN] & s2[WRN];
  assign ser_s2   = s2[SER +: 2];
  assign ser_sp   = sp[SER +: 2];
  assign trig     = trig_mode ? (ser_sp[ser_pick] & ~ser_s2[ser_pick])
                              : (sp[RSO] & ~s2[RSO]);

  assign rec_a = {2'b00, s2[A15], s2[AW-1:0]};
  assign rec_r = {2'b01, 1'b0,    s2[AW-1:0]};
  assign rec_w = {2'b10, 1'b0,    s2[AW-1:0]};
  assign ev    = {wr_rise, rd_rise, ale_fall} & {3{capturing}};

  assign pos0  = PW'(count);
  assign pos1  = pos0 + PW'(ev[0]);
  assign pos2  = pos1 + PW'(ev[1]);
  assign total = pos2 + PW'(ev[2]);
  assign nxt   = (total > DEP) ? DEP : total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      armed     <= 1'b0;
      capturing <= 1'b0;
    end else if (arm) begin
      count     <= '0;
      armed     <= 1'b1;
      capturing <= 1'b0;
    end else begin
      if (armed && trig) begin
        armed     <= 1'b0;
        capturing <= 1'b1;
      end
      if (capturing) begin
        count <= nxt[CW-1:0];
        if (nxt == DEP) capturing <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ev[0] && pos0 < DEP) mem[pos0[IW-1:0]] <= rec_a;
    if (ev[1] && pos1 < DEP) mem[pos1[IW-1:0]] <= rec_r;
    if (ev[2] && pos2 < DEP) mem[pos2[IW-1:0]] <= rec_w;
  end

  assign rec       = mem[rd_idx];
  assign rec_count = count;
  assign full      = (count == CW'(DEPTH));

  // R10
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= CW'(DEPTH));
  // R10
  full_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !capturing);
  // R11
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (rec_count == '0 && !capturing));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!capturing && !arm) |=> rec_count == $past(rec_count));
  // R5
  ale_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && ale_fall && !arm && !full) |=> rec_count != $past(rec_count));
endmodule

// File: tb/bus_trace_capture_tb.sv
`timescale 1ns/1ps
module bus_trace_capture_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_ad = 0;
  logic bus_ale = 0, bus_rd_n = 1, bus_wr_n = 1, bus_a15 = 0, bus_rst_out = 1;
  logic [1:0] ser_line = 2'b11;
  logic trig_mode = 0, ser_pick = 0, arm = 0;
  logic [5:0] rd_idx = 0;
  logic [10:0] rec;
  logic [6:0] rec_count;
  logic full, capturing;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_trace_capture dut_i (.clk, .rst_n, .bus_ad, .bus_ale, .bus_rd_n, .bus_wr_n,
    .bus_a15, .bus_rst_out, .ser_line, .trig_mode, .ser_pick, .arm, .rd_idx,
    .rec, .rec_count, .full, .capturing);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic hi, input logic [7:0] d);
    bus_ad = a; bus_a15 = hi; bus_ale = 1; step();
    bus_ale = 0; step();
    bus_ad = d; bus_rd_n = 0; step();
    bus_rd_n = 1; step();
  endtask

  task automatic bus_write(input logic [7:0] d);
    bus_ad = d; bus_wr_n = 0; step();
    bus_wr_n = 1; step();
  endtask

  task automatic chk_rec(string req, int idx, int exp);
    @(negedge clk); rd_idx = 6'(idx); #1;
    chk(req, int'(rec), exp);
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", int'(rec_count), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 capturing", int'(capturing), 0);
  endtask

  task automatic t_no_trigger();
    bus_read(8'h11, 0, 8'h22);
    chk("R2 unarmed", int'(rec_count), 0);
    trig_mode = 0; bus_rst_out = 1;
    pulse_arm(); step();
    bus_read(8'h33, 0, 8'h44);
    chk("R2 armed no trigger", int'(rec_count), 0);
    chk("R2 not capturing", int'(capturing), 0);
  endtask

  task automatic t_reset_release();
    bus_rst_out = 0; step();
    chk("R3 reset-release trigger", int'(capturing), 1);
    bus_read(8'h00, 0, 8'hC3);
    bus_read(8'h01, 0, 8'h25);
    bus_read(8'h02, 0, 8'h80);
    bus_ad = 8'h25; bus_a15 = 1; bus_ale = 1; step();
    bus_ale = 0; repeat (3) @(negedge clk);
    chk("R8 count after fetch", int'(rec_count), 7);
    chk_rec("R5 addr 00", 0, 11'h000);
    chk_rec("R6 read C3", 1, 11'h2C3);
    chk_rec("R5 addr 01", 2, 11'h001);
    chk_rec("R6 read 25", 3, 11'h225);
    chk_rec("R5 addr 02", 4, 11'h002);
    chk_rec("R6 read 80", 5, 11'h280);
    chk_rec("R5 jump target a15", 6, 11'h125);
  endtask

  task automatic t_write();
    step();
    bus_ad = 8'h40; bus_a15 = 1; bus_ale = 1; step();
    bus_ale = 0; step();
    bus_write(8'h5A);
    chk("R8 count after write", int'(rec_count), 9);
    chk_rec("R5 write address", 7, 11'h140);
    chk_rec("R7 write data", 8, 11'h45A);
    chk_rec("R12 readout earlier index", 3, 11'h225);
  endtask

  task automatic t_serial();
    bus_rst_out = 1; trig_mode = 1; ser_pick = 1; ser_line = 2'b11; bus_a15 = 0;
    pulse_arm(); step();
    chk("R11 arm clears count", int'(rec_count), 0);
    bus_rst_out = 0; step();
    bus_read(8'h10, 0, 8'h20);
    chk("R3 reset-out ignored in serial mode", int'(rec_count), 0);
    ser_line[0] = 0; step();
    bus_read(8'h10, 0, 8'h20);
    chk("R4 unselected line ignored", int'(rec_count), 0);
    ser_line[1] = 0; step();
    chk("R4 start-bit trigger", int'(capturing), 1);
    bus_ad = 8'h77; bus_ale = 1; bus_rd_n = 0; bus_wr_n = 0; step();
    bus_ale = 0; bus_rd_n = 1; bus_wr_n = 1; step();
    chk("R9 three same-cycle records", int'(rec_count), 3);
    chk_rec("R9 first address", 0, 11'h077);
    chk_rec("R9 second read", 1, 11'h277);
    chk_rec("R9 third write", 2, 11'h477);
  endtask

  task automatic t_full();
    trig_mode = 0; bus_rst_out = 1;
    pulse_arm(); step();
    bus_rst_out = 0; step();
    for (int i = 0; i < 70; i++) bus_write(8'(i));
    chk("R10 count saturates", int'(rec_count), 64);
    chk("R10 full", int'(full), 1);
    chk("R10 capturing stops", int'(capturing), 0);
    chk_rec("R10 first kept", 0, 11'h400);
    chk_rec("R10 last kept", 63, 11'h43F);
    bus_write(8'hEE);
    chk("R10 extra ignored", int'(rec_count), 64);
    chk_rec("R10 no wrap", 0, 11'h400);
    bus_rst_out = 1;
    pulse_arm(); step();
    chk("R11 rearm count", int'(rec_count), 0);
    chk("R11 rearm full", int'(full), 0);
    bus_write(8'h99);
    chk("R11 waits for trigger", int'(rec_count), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_no_trigger();
    t_reset_release();
    t_write();
    t_serial();
    t_full();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule